// File: doc/BRIEF.md
# Byte-wide flash bus control front-end

This block is a clocked front end for a byte-wide parallel flash device. It samples the active-low chip-select, read-enable, write-strobe and hardware-reset pins through a synchronizer and sorts every bus cycle into one of three kinds: a read that drives the data bus, a write that is handed on, or a cycle that is ignored. A write goes downstream only after the write strobe has passed a glitch filter and only when the other control pins were in the exact write combination for the whole low phase. A qualified write reaches the command decoder as a one-cycle strobe that carries the address and data present when the write strobe went high.

Reads return array data, or an identifier byte when the command decoder has put the part in identifier mode. The hardware-reset pin silences the bus, discards any write in progress and tells downstream logic to return to read-array state. A write strobe that is already low when the block leaves power-up reset cannot produce a command.

Top module: `fbus_frontend`

## Requirements
- R1: While `rst` is high and on the cycle after it, `dq_en` and `wr_stb` are 0 and `to_read` is 1.
- R2: `dq_en` is 1 only while chip-select and read-enable are both low and the reset pin is high. `dq_o` then carries `array_data` for `rd_addr` when `id_mode` is 0. In every other case `dq_en` is 0.
- R3: With `id_mode` at 1 and address bit 1 at 0, a read returns 8'hDA when address bit 0 is 0 and 8'h0B when it is 1. With address bit 1 at 1 it returns 8'h80.
- R4: Every identifier byte has odd parity. Bit 7 is the parity bit.
- R5: When chip-select is low, read-enable is high and the write strobe is held low for at least WE_MIN synchronized cycles and then rises, `wr_stb` pulses for exactly one cycle. `wr_addr` and `wr_data` hold the address and data present at the rising edge of the write strobe.
- R6: If read-enable goes low or chip-select goes high at any point during the low phase of the write strobe, that write produces no `wr_stb`.
- R7: A write-strobe low phase shorter than WE_MIN synchronized cycles produces no `wr_stb`.
- R8: If the write strobe is already low when `rst` is released, the rising edge that ends that low phase produces no `wr_stb`. The next full write is accepted.
- R9: While the reset pin is low, `dq_en` is 0, no `wr_stb` is produced and `to_read` is 1. A write whose low phase overlaps the reset pulse is dropped. After the pin is released, `to_read` returns to 0 and new writes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Chip-select pin, active low |
| oe_n | input | 1 | Read-enable pin, active low |
| we_n | input | 1 | Write-strobe pin, active low |
| hwrst_n | input | 1 | Hardware-reset pin, active low |
| addr | input | AW | Address pins |
| dq_i | input | 8 | Data bus, input side |
| id_mode | input | 1 | Identifier mode, from the command decoder |
| array_data | input | 8 | Array byte at `rd_addr` |
| dq_o | output | 8 | Data bus, output side |
| dq_en | output | 1 | Data bus drive enable. The bus is high-impedance when this is 0 |
| rd_addr | output | AW | Synchronized address for array reads |
| wr_stb | output | 1 | One-cycle qualified-write strobe |
| wr_addr | output | AW | Address of the qualified write |
| wr_data | output | 8 | Data of the qualified write |
| to_read | output | 1 | Tells downstream logic to return to read-array state |

## Verification
The bench targets the write-strobe width at both sides of WE_MIN. A filter that is off by one either passes a pulse one cycle too short or rejects one that is exactly long enough. It also spoils write cycles by briefly pulling read-enable low or chip-select high in the middle of the low phase. A design that checks the pins only at the rising edge would wrongly emit a strobe for these.

Two more cases cover power-up and the reset pin. Holding the write strobe low through power-up exposes a design that treats the first rising edge as a command. Overlapping a write with a reset pulse catches a design that resumes the interrupted cycle once the pin is released. Finally, data is changed partway through the low phase to confirm that the value latched is the one at the rising edge, not the one at the falling edge.

// File: rtl/fbus_pkg.sv
package fbus_pkg;

    // control vector bit positions after synchronization
    localparam int CTL_W   = 4;
    localparam int CTL_CE  = 3;
    localparam int CTL_OE  = 2;
    localparam int CTL_WE  = 1;
    localparam int CTL_RST = 0;

    // conservative power-up view: deselected, strobe assumed low, reset asserted
    localparam logic [CTL_W-1:0] CTL_PWRUP = 4'b1100;

    localparam logic [6:0] ID_MFR_BODY = 7'h5A;
    localparam logic [6:0] ID_DEV_BODY = 7'h0B;
    localparam logic [6:0] ID_RSV_BODY = 7'h00;

    // attach an odd-parity bit in position 7
    function automatic logic [7:0] id_with_parity(input logic [6:0] body);
        return {~^body, body};
    endfunction

    function automatic logic [7:0] id_lookup(input logic [1:0] sel);
        logic [7:0] r;
        if (sel[1])
            r = id_with_parity(ID_RSV_BODY);
        else if (sel[0])
            r = id_with_parity(ID_DEV_BODY);
        else
            r = id_with_parity(ID_MFR_BODY);
        return r;
    endfunction

endpackage

// File: rtl/fbus_sync.sv
module fbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fbus_we_filter.sv
module fbus_we_filter
    import fbus_pkg::*;
#(
    parameter int AW     = 18,
    parameter int WE_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl_s,
    input  logic [AW-1:0]    addr_s,
    input  logic [7:0]       data_s,
    output logic             wr_busy,
    output logic             wr_stb,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data
);
    localparam int CW = $clog2(WE_MIN + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(WE_MIN);

    logic          ce_n_s, oe_n_s, we_n_s, rst_n_s;
    logic [CW-1:0] low_cnt;
    logic          spoiled;
    logic          lockout;
    logic          accept;

    assign ce_n_s  = ctl_s[CTL_CE];
    assign oe_n_s  = ctl_s[CTL_OE];
    assign we_n_s  = ctl_s[CTL_WE];
    assign rst_n_s = ctl_s[CTL_RST];

    // rising edge of a long-enough, clean low phase in the write combination
    assign accept = we_n_s && (low_cnt == CNT_FULL) && !spoiled && !lockout
                    && !ce_n_s && oe_n_s && rst_n_s;

    assign wr_busy = !we_n_s && (low_cnt == CNT_FULL) && !spoiled;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            spoiled <= 1'b0;
            lockout <= 1'b1;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (we_n_s) begin
                if (accept) begin
                    wr_stb  <= 1'b1;
                    wr_addr <= addr_s;
                    wr_data <= data_s;
                end
                low_cnt <= '0;
                spoiled <= 1'b0;
                lockout <= 1'b0;
            end else begin
                if (!rst_n_s)
                    low_cnt <= '0;
                else if (low_cnt != CNT_FULL)
                    low_cnt <= low_cnt + 1'b1;
                if (ce_n_s || !oe_n_s || !rst_n_s || lockout)
                    spoiled <= 1'b1;
            end
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R5
    AST_STB_WRITE_COMBO: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(!ce_n_s && oe_n_s)); // R6
    AST_SHORT_PULSE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (we_n_s && low_cnt != CNT_FULL) |=> !wr_stb); // R7
    AST_PWRUP_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        lockout |=> !wr_stb); // R8
endmodule

// File: rtl/fbus_read_path.sv
module fbus_read_path
    import fbus_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl_s,
    input  logic [AW-1:0]    addr_s,
    input  logic             wr_busy,
    input  logic             id_mode,
    input  logic [7:0]       array_data,
    output logic [7:0]       dq_o,
    output logic             dq_en,
    output logic             to_read
);
    logic drive_ok;
    logic from_id;

    assign drive_ok = !ctl_s[CTL_CE] && !ctl_s[CTL_OE] && ctl_s[CTL_RST] && !wr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_en   <= 1'b0;
            dq_o    <= '0;
            from_id <= 1'b0;
            to_read <= 1'b1;
        end else begin
            dq_en   <= drive_ok;
            dq_o    <= id_mode ? id_lookup(addr_s[1:0]) : array_data;
            from_id <= id_mode;
            to_read <= !ctl_s[CTL_RST];
        end
    end

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        dq_en |-> $past(!ctl_s[CTL_CE] && !ctl_s[CTL_OE])); // R2
    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
        (dq_en && from_id) |-> (^dq_o)); // R4
    AST_RESET_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl_s[CTL_RST] |=> (!dq_en && to_read)); // R9
endmodule

// File: rtl/fbus_frontend.sv
module fbus_frontend
    import fbus_pkg::*;
#(
    parameter int AW          = 18,
    parameter int SYNC_STAGES = 2,
    parameter int WE_MIN      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hwrst_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_i,
    input  logic          id_mode,
    input  logic [7:0]    array_data,
    output logic [7:0]    dq_o,
    output logic          dq_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          to_read
);
    localparam int PW = AW + 8;

    logic [CTL_W-1:0] ctl_s;
    logic [PW-1:0]    bus_s;
    logic [AW-1:0]    addr_s;
    logic [7:0]       data_s;
    logic             wr_busy;

    fbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_PWRUP)) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ce_n, oe_n, we_n, hwrst_n}),
        .q   (ctl_s)
    );

    // address and data follow the same delay so they stay aligned with the strobe
    fbus_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({addr, dq_i}),
        .q   (bus_s)
    );

    assign addr_s  = bus_s[PW-1:8];
    assign data_s  = bus_s[7:0];
    assign rd_addr = addr_s;

    fbus_we_filter #(.AW(AW), .WE_MIN(WE_MIN)) u_we_filter (
        .clk     (clk),
        .rst     (rst),
        .ctl_s   (ctl_s),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .wr_busy (wr_busy),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fbus_read_path #(.AW(AW)) u_read_path (
        .clk        (clk),
        .rst        (rst),
        .ctl_s      (ctl_s),
        .addr_s     (addr_s),
        .wr_busy    (wr_busy),
        .id_mode    (id_mode),
        .array_data (array_data),
        .dq_o       (dq_o),
        .dq_en      (dq_en),
        .to_read    (to_read)
    );

    AST_PWR_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!dq_en && !wr_stb && to_read)); // R1
    AST_NO_WRITE_IN_PIN_RESET: assert property (@(posedge clk) disable iff (rst)
        !ctl_s[CTL_RST] |=> !wr_stb); // R9
endmodule

// File: tb/tb_fbus_frontend.sv
module tb_fbus_frontend;
    localparam int AW = 18;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, we_n, hwrst_n, id_mode;
    logic [AW-1:0] addr;
    logic [7:0]    dq_i, array_data, dq_o, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          dq_en, wr_stb, to_read;

    int total = 0;
    int bad   = 0;
    int stb_cnt = 0;
    logic [AW-1:0] last_a;
    logic [7:0]    last_d;

    always #5 clk = ~clk;

    assign array_data = rd_addr[7:0] ^ 8'h3C;

    fbus_frontend #(.AW(AW), .SYNC_STAGES(2), .WE_MIN(NW)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hwrst_n(hwrst_n), .addr(addr), .dq_i(dq_i), .id_mode(id_mode),
        .array_data(array_data), .dq_o(dq_o), .dq_en(dq_en), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .to_read(to_read)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt = stb_cnt + 1;
            last_a  = wr_addr;
            last_d  = wr_data;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        ce_n = 1; oe_n = 1; we_n = 1; hwrst_n = 1; id_mode = 0;
        ncyc(6);
    endtask

    // spoil: 0 none, 1 oe low mid-pulse, 2 ce high mid-pulse, 3 reset pin mid-pulse
    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                            input int low, input int spoil);
        addr = a; dq_i = ~d; ce_n = 0; oe_n = 1;
        ncyc(1);
        we_n = 0;
        for (int i = 0; i < low; i++) begin
            if (i == 1 && spoil == 1) oe_n = 0;
            if (i == 1 && spoil == 2) ce_n = 1;
            if (i == 1 && spoil == 3) hwrst_n = 0;
            if (i == 2) begin oe_n = 1; ce_n = 0; hwrst_n = 1; end
            if (i == low - 1) dq_i = d;
            ncyc(1);
        end
        we_n = 1;
        ncyc(6);
        ce_n = 1;
        ncyc(2);
    endtask

    task automatic t_reset();
        rst = 1;
        ce_n = 0; oe_n = 1; we_n = 0; hwrst_n = 1; id_mode = 0;
        addr = 18'h00155; dq_i = 8'hA5;
        ncyc(3);
        chk(dq_en == 0,   "R1 dq_en in reset", dq_en, 0);
        chk(wr_stb == 0,  "R1 wr_stb in reset", wr_stb, 0);
        chk(to_read == 1, "R1 to_read in reset", to_read, 1);
        rst = 0;
        ncyc(1);
        chk(dq_en == 0 && wr_stb == 0, "R1 after release", {dq_en, wr_stb}, 0);
    endtask

    task automatic t_pwrup_lock();
        int s0;
        ncyc(6);
        s0 = stb_cnt;
        we_n = 1;
        ncyc(8);
        chk(stb_cnt == s0, "R8 held-low strobe refused", stb_cnt - s0, 0);
        ce_n = 1;
        ncyc(4);
        s0 = stb_cnt;
        do_write(18'h2AAAA, 8'h55, NW + 1, 0);
        chk(stb_cnt == s0 + 1, "R8 next write accepted", stb_cnt - s0, 1);
    endtask

    task automatic t_write();
        int s0 = stb_cnt;
        do_write(18'h3C0DE, 8'h9E, NW + 2, 0);
        chk(stb_cnt == s0 + 1, "R5 one strobe", stb_cnt - s0, 1);
        chk(last_a == 18'h3C0DE, "R5 address latched", last_a, 18'h3C0DE);
        chk(last_d == 8'h9E, "R5 data at rising edge", last_d, 8'h9E);
    endtask

    task automatic t_glitch();
        int s0 = stb_cnt;
        do_write(18'h00011, 8'h11, NW - 1, 0);
        chk(stb_cnt == s0, "R7 short pulse dropped", stb_cnt - s0, 0);
        s0 = stb_cnt;
        do_write(18'h00022, 8'h22, NW, 0);
        chk(stb_cnt == s0 + 1, "R7 exact width accepted", stb_cnt - s0, 1);
        chk(last_d == 8'h22, "R7 data of boundary write", last_d, 8'h22);
    endtask

    task automatic t_inhibit();
        int s0 = stb_cnt;
        do_write(18'h00033, 8'h33, NW + 3, 1);
        chk(stb_cnt == s0, "R6 read-enable low mid-write", stb_cnt - s0, 0);
        s0 = stb_cnt;
        do_write(18'h00044, 8'h44, NW + 3, 2);
        chk(stb_cnt == s0, "R6 chip-select high mid-write", stb_cnt - s0, 0);
    endtask

    task automatic t_read();
        addr = 18'h01234; ce_n = 0; oe_n = 0;
        ncyc(5);
        chk(dq_en == 1, "R2 drive on read", dq_en, 1);
        chk(dq_o == (8'h34 ^ 8'h3C), "R2 array data", dq_o, 8'h34 ^ 8'h3C);
        oe_n = 1;
        ncyc(5);
        chk(dq_en == 0, "R2 hi-z read-enable high", dq_en, 0);
        ce_n = 1; oe_n = 0;
        ncyc(5);
        chk(dq_en == 0, "R2 hi-z deselected", dq_en, 0);
        oe_n = 1;
        ncyc(2);
    endtask

    task automatic t_ident();
        logic [7:0] exp_v [3] = '{8'hDA, 8'h0B, 8'h80};
        logic [1:0] sel_v [3] = '{2'b00, 2'b01, 2'b10};
        id_mode = 1; ce_n = 0; oe_n = 0;
        for (int k = 0; k < 3; k++) begin
            addr = {16'h0100, sel_v[k]};
            ncyc(5);
            chk(dq_en == 1 && dq_o == exp_v[k], "R3 identifier byte", dq_o, exp_v[k]);
            chk(^dq_o == 1'b1, "R4 odd parity", ^dq_o, 1);
        end
        id_mode = 0; ce_n = 1; oe_n = 1;
        ncyc(3);
    endtask

    task automatic t_hwreset();
        int s0;
        addr = 18'h00077; ce_n = 0; oe_n = 0;
        ncyc(5);
        hwrst_n = 0;
        ncyc(5);
        chk(dq_en == 0, "R9 bus quiet in reset", dq_en, 0);
        chk(to_read == 1, "R9 to_read asserted", to_read, 1);
        hwrst_n = 1;
        ncyc(5);
        chk(to_read == 0, "R9 to_read released", to_read, 0);
        chk(dq_en == 1, "R9 read resumes", dq_en, 1);
        ce_n = 1; oe_n = 1;
        ncyc(3);
        s0 = stb_cnt;
        do_write(18'h00066, 8'h66, NW + 4, 3);
        chk(stb_cnt == s0, "R9 interrupted write dropped", stb_cnt - s0, 0);
        s0 = stb_cnt;
        do_write(18'h00088, 8'h88, NW + 1, 0);
        chk(stb_cnt == s0 + 1 && last_d == 8'h88, "R9 write after reset", stb_cnt - s0, 1);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pwrup_lock();
        go_idle();
        t_write();
        t_glitch();
        t_inhibit();
        t_read();
        t_ident();
        t_hwreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule